// File: doc/BRIEF.md
# Network Packet Receive Engine with Deferred Copy

This block takes packets of 16-bit flits from a network input queue and stores them in a local receive buffer RAM, one flit per cycle. The first flit is kept as a routing word whatever its value. The second flit gives the number of payload flits that follow. When the whole packet is in the buffer, the engine reports the packet length to the CPU and raises an interrupt. It accepts no further flits until the CPU has dealt with the packet.

The CPU then supplies a destination address and a flit count and pulses the program strobe. The engine holds the CPU stalled while it copies that many flits from the buffer into main memory, one flit per cycle. After the last write it releases the stall and clears the interrupt together. It then waits for the CPU to drop the strobe before it looks for the next packet. This stops one long strobe from starting a second copy.

Top module: `noc_rx_dma`

## Requirements
- R1: After reset, `flit_ready` is 1 and `irq`, `stall`, `rx_status`, `buf_we` and `mem_we` are all 0.
- R2: The first accepted flit of a packet is written to buffer byte offset 0 whatever its value. Every later flit goes to the previous offset plus 2. A buffer write is issued on the cycle after the flit is accepted.
- R3: The second accepted flit is written to buffer offset 2. From the cycle after its acceptance, `rx_status` equals its value plus 2, modulo 2^16.
- R4: When the size flit carries N > 0, exactly N further flits are accepted and written at offsets 4, 6, and so on. On the cycle after the last one is accepted, `irq` is 1 and `flit_ready` is 0.
- R5: When the size flit carries 0, `irq` is 1 and `flit_ready` is 0 on the cycle after the size flit is accepted, and no payload flit is taken.
- R6: While the interrupt waits for the CPU, `flit_ready` stays 0 and a valid flit on the input is not consumed.
- R7: On the cycle after `prog_recv` is seen high while the engine waits for the CPU, `stall` is 1 and `rx_status` is 0. `prog_addr` and `prog_size` are captured at that point.
- R8: For a programmed count P > 0, main memory receives exactly P writes on P consecutive cycles. Write i goes to address `prog_addr + 2*i` and carries buffer word i. P is used as given, with no +2 adjustment.
- R9: `stall` and `irq` fall on the same cycle. This happens only after the last main-memory write, and `mem_we` is never 1 while `stall` is 0.
- R10: A programmed count of 0 causes no main-memory write and releases `stall` and `irq` directly.
- R11: After the copy, `flit_ready` stays 0 while `prog_recv` is still 1. On the cycle after `prog_recv` drops, `flit_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flit_valid | input | 1 | Input flit present |
| flit_data | input | 16 | Input flit |
| flit_ready | output | 1 | Engine takes the flit this cycle |
| buf_we | output | 1 | Receive buffer write enable |
| buf_addr | output | 8 | Receive buffer byte address (write and read) |
| buf_wdata | output | 16 | Receive buffer write data |
| buf_rdata | input | 16 | Receive buffer read data, one cycle after address |
| mem_we | output | 1 | Main memory write enable |
| mem_addr | output | 32 | Main memory byte address |
| mem_wdata | output | 16 | Main memory write data |
| prog_recv | input | 1 | CPU program-receive strobe (level) |
| prog_addr | input | 32 | CPU destination base address |
| prog_size | input | 16 | CPU flit count to copy |
| rx_status | output | 16 | Received length (size flit plus 2), cleared on program |
| irq | output | 1 | Packet-ready interrupt |
| stall | output | 1 | CPU stall during copy |

## Verification
A wrong remaining count or pointer shows up within one cycle of the last payload flit. It appears as an early or late interrupt, an extra or missing buffer write, or a write at the wrong offset. A fault in the copy pipeline shows up on the first main-memory write as a wrong address or data word. It can also show up as a gap between writes, or as a stall that drops before the last write or one cycle apart from the interrupt. A fault in the handshake guard appears as `flit_ready` returning while the strobe is still high.

// File: rtl/noc_rx_dma_pkg.sv
package noc_rx_dma_pkg;
  typedef enum logic [2:0] {
    ST_ROUTE,
    ST_LEN,
    ST_BODY,
    ST_HOLD,
    ST_COPY,
    ST_RELEASE
  } rx_state_e;
endpackage

// File: rtl/noc_rx_dma_ctrl.sv
module noc_rx_dma_ctrl
  import noc_rx_dma_pkg::*;
#(
  parameter int FLIT_W = 16,
  parameter int BUF_AW = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flit_valid,
  input  logic [FLIT_W-1:0] flit_data,
  output logic              flit_ready,
  input  logic              prog_recv,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [CNT_W-1:0]  prog_size,
  input  logic              pipe_busy,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_addr,
  output logic [FLIT_W-1:0] buf_wdata,
  output logic              rd_issue,
  output logic [ADDR_W-1:0] dest_base,
  output logic [CNT_W-1:0]  rx_status,
  output logic              irq,
  output logic              stall
);
  localparam int FLIT_BYTES = FLIT_W / 8;
  localparam logic [BUF_AW-1:0] STEP = BUF_AW'(FLIT_BYTES);
  localparam logic [CNT_W-1:0] HDR_FLITS = CNT_W'(2);

  rx_state_e state_q;
  logic [CNT_W-1:0]  rem_q;
  logic [BUF_AW-1:0] ptr_q;
  logic              take;

  assign flit_ready = (state_q == ST_ROUTE) || (state_q == ST_LEN) || (state_q == ST_BODY);
  assign take = flit_valid && flit_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_ROUTE;
      rem_q     <= '0;
      ptr_q     <= '0;
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_wdata <= '0;
      rd_issue  <= 1'b0;
      dest_base <= '0;
      rx_status <= '0;
      irq       <= 1'b0;
      stall     <= 1'b0;
    end else begin
      buf_we   <= 1'b0;
      rd_issue <= 1'b0;
      case (state_q)
        ST_ROUTE: if (take) begin
          buf_we    <= 1'b1;
          buf_addr  <= '0;
          buf_wdata <= flit_data;
          ptr_q     <= STEP;
          state_q   <= ST_LEN;
        end
        ST_LEN: if (take) begin
          buf_we    <= 1'b1;
          buf_addr  <= ptr_q;
          buf_wdata <= flit_data;
          ptr_q     <= ptr_q + STEP;
          rx_status <= CNT_W'(flit_data) + HDR_FLITS;
          rem_q     <= CNT_W'(flit_data);
          if (flit_data == '0) begin
            irq     <= 1'b1;
            state_q <= ST_HOLD;
          end else begin
            state_q <= ST_BODY;
          end
        end
        ST_BODY: if (take) begin
          buf_we    <= 1'b1;
          buf_addr  <= ptr_q;
          buf_wdata <= flit_data;
          ptr_q     <= ptr_q + STEP;
          rem_q     <= rem_q - 1'b1;
          if (rem_q == CNT_W'(1)) begin
            irq     <= 1'b1;
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: if (prog_recv) begin
          rx_status <= '0;
          rem_q     <= prog_size;
          ptr_q     <= '0;
          dest_base <= prog_addr;
          stall     <= 1'b1;
          state_q   <= ST_COPY;
        end
        ST_COPY: begin
          if (rem_q != '0) begin
            rd_issue <= 1'b1;
            buf_addr <= ptr_q;
            ptr_q    <= ptr_q + STEP;
            rem_q    <= rem_q - 1'b1;
          end else if (!rd_issue && !pipe_busy) begin
            stall   <= 1'b0;
            irq     <= 1'b0;
            state_q <= ST_RELEASE;
          end
        end
        ST_RELEASE: if (!prog_recv) state_q <= ST_ROUTE;
        default: state_q <= ST_ROUTE;
      endcase
    end
  end
endmodule

// File: rtl/noc_rx_dma_copy.sv
module noc_rx_dma_copy #(
  parameter int FLIT_W = 16,
  parameter int BUF_AW = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_issue,
  input  logic [BUF_AW-1:0] rd_ptr,
  input  logic [ADDR_W-1:0] dest_base,
  input  logic [FLIT_W-1:0] buf_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [FLIT_W-1:0] mem_wdata,
  output logic              busy
);
  logic              s1_valid;
  logic [BUF_AW-1:0] s1_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_ptr    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      s1_valid <= rd_issue;
      s1_ptr   <= rd_ptr;
      mem_we   <= s1_valid;
      if (s1_valid) begin
        mem_addr  <= dest_base + ADDR_W'(s1_ptr);
        mem_wdata <= buf_rdata;
      end
    end
  end

  assign busy = s1_valid || mem_we;
endmodule

// File: rtl/noc_rx_dma.sv
module noc_rx_dma #(
  parameter int FLIT_W = 16,
  parameter int BUF_AW = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flit_valid,
  input  logic [FLIT_W-1:0] flit_data,
  output logic              flit_ready,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_addr,
  output logic [FLIT_W-1:0] buf_wdata,
  input  logic [FLIT_W-1:0] buf_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [FLIT_W-1:0] mem_wdata,
  input  logic              prog_recv,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [CNT_W-1:0]  prog_size,
  output logic [CNT_W-1:0]  rx_status,
  output logic              irq,
  output logic              stall
);
  logic              rd_issue;
  logic              pipe_busy;
  logic [ADDR_W-1:0] dest_base;

  noc_rx_dma_ctrl #(
    .FLIT_W(FLIT_W), .BUF_AW(BUF_AW), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .flit_valid(flit_valid), .flit_data(flit_data), .flit_ready(flit_ready),
    .prog_recv(prog_recv), .prog_addr(prog_addr), .prog_size(prog_size),
    .pipe_busy(pipe_busy),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .rd_issue(rd_issue), .dest_base(dest_base),
    .rx_status(rx_status), .irq(irq), .stall(stall)
  );

  noc_rx_dma_copy #(
    .FLIT_W(FLIT_W), .BUF_AW(BUF_AW), .ADDR_W(ADDR_W)
  ) u_copy (
    .clk(clk), .rst(rst),
    .rd_issue(rd_issue), .rd_ptr(buf_addr), .dest_base(dest_base),
    .buf_rdata(buf_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(pipe_busy)
  );
endmodule

// File: rtl/noc_rx_dma_chk.sv
module noc_rx_dma_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             flit_ready,
  input logic             buf_we,
  input logic             mem_we,
  input logic             prog_recv,
  input logic [CNT_W-1:0] rx_status,
  input logic             irq,
  input logic             stall
);
  // R6
  no_take_in_copy_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> !flit_ready);

  // R9
  write_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> stall);

  // R2
  fill_without_stall_chk: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> !stall);

  // R7
  stall_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |-> (rx_status == '0) && $past(prog_recv));

  // R9
  joint_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> !irq);

  // R4
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !flit_ready && !stall);
endmodule

bind noc_rx_dma noc_rx_dma_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .flit_ready(flit_ready), .buf_we(buf_we),
  .mem_we(mem_we), .prog_recv(prog_recv), .rx_status(rx_status),
  .irq(irq), .stall(stall)
);

// File: tb/sim_noc_rx_dma.sv
`timescale 1ns/1ps
module sim_noc_rx_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flit_valid = 1'b0;
  logic [15:0] flit_data = '0;
  logic        flit_ready;
  logic        buf_we;
  logic [7:0]  buf_addr;
  logic [15:0] buf_wdata;
  logic [15:0] buf_rdata = '0;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        prog_recv = 1'b0;
  logic [31:0] prog_addr = '0;
  logic [15:0] prog_size = '0;
  logic [15:0] rx_status;
  logic        irq;
  logic        stall;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int bw_idx = 0;
  int mw_idx = 0;
  int first_cyc = 0;
  int last_cyc = 0;
  logic [31:0] cur_base = '0;
  logic [15:0] exp_buf [0:127];
  logic [15:0] bram [0:127];

  always #4 clk = ~clk;

  noc_rx_dma u0 (
    .clk(clk), .rst(rst), .flit_valid(flit_valid), .flit_data(flit_data),
    .flit_ready(flit_ready), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .prog_recv(prog_recv),
    .prog_addr(prog_addr), .prog_size(prog_size), .rx_status(rx_status),
    .irq(irq), .stall(stall)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (buf_we) bram[buf_addr[7:1]] <= buf_wdata;
    buf_rdata <= bram[buf_addr[7:1]];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && buf_we) begin
      chk(buf_addr == 8'(2 * bw_idx), "R2 buffer offset", buf_addr, 2 * bw_idx);
      chk(buf_wdata == exp_buf[bw_idx], "R2 buffer data", buf_wdata, exp_buf[bw_idx]);
      bw_idx++;
    end
    if (!rst && mem_we) begin
      if (mw_idx == 0) first_cyc = cyc;
      last_cyc = cyc;
      chk(mem_addr == cur_base + 32'(2 * mw_idx), "R8 memory address", mem_addr, cur_base + 32'(2 * mw_idx));
      chk(mem_wdata == exp_buf[mw_idx], "R8 memory data", mem_wdata, exp_buf[mw_idx]);
      chk(stall == 1'b1, "R9 write under stall", stall, 1);
      mw_idx++;
    end
  end

  task automatic put_flit(input logic [15:0] d);
    @(negedge clk);
    flit_valid = 1'b1;
    flit_data  = d;
    while (!flit_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic run_pkt(input logic [15:0] hdr, input int size, input int psize, input logic [31:0] base);
    string rq;
    rq = (size == 0) ? "R5" : "R4";
    bw_idx = 0;
    exp_buf[0] = hdr;
    exp_buf[1] = 16'(size);
    for (int i = 0; i < size; i++) exp_buf[2 + i] = hdr ^ 16'(i * 16'h1111 + size * 7);
    put_flit(hdr);
    put_flit(16'(size));
    for (int i = 0; i < size; i++) put_flit(exp_buf[2 + i]);
    @(negedge clk);
    flit_data = 16'hDEAD;
    chk(irq == 1'b1, rq, irq, 1);
    chk(flit_ready == 1'b0, rq, flit_ready, 0);
    chk(rx_status == 16'(size + 2), "R3 status", rx_status, size + 2);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(flit_ready == 1'b0, "R6 held while waiting", flit_ready, 0);
    end
    flit_valid = 1'b0;
    chk(bw_idx == size + 2, rq, bw_idx, size + 2);
    chk(bram[0] == hdr, "R2 first word", bram[0], hdr);
    chk(bram[1] == 16'(size), "R3 size word", bram[1], size);
    mw_idx = 0;
    cur_base = base;
    prog_addr = base;
    prog_size = 16'(psize);
    prog_recv = 1'b1;
    @(negedge clk);
    prog_addr = 32'hFFFF_0000;
    prog_size = 16'h7F;
    chk(stall == 1'b1, "R7 stall", stall, 1);
    chk(rx_status == 16'h0, "R7 status clear", rx_status, 0);
    for (int k = 0; k < 200 && stall; k++) @(negedge clk);
    chk(stall == 1'b0, "R9 stall released", stall, 0);
    chk(irq == 1'b0, "R9 irq with stall", irq, 0);
    chk(mw_idx == psize, (psize == 0) ? "R10 no writes" : "R8 write count", mw_idx, psize);
    if (psize > 0) chk(last_cyc - first_cyc + 1 == psize, "R8 back to back", last_cyc - first_cyc + 1, psize);
    flit_valid = 1'b1;
    flit_data = 16'hBEEF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(flit_ready == 1'b0, "R11 strobe still high", flit_ready, 0);
    end
    flit_valid = 1'b0;
    chk(bw_idx == size + 2, "R11 nothing taken", bw_idx, size + 2);
    prog_recv = 1'b0;
    @(negedge clk);
    chk(flit_ready == 1'b1, "R11 ready again", flit_ready, 1);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(flit_ready == 1'b1, "R1 ready", flit_ready, 1);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(stall == 1'b0, "R1 stall", stall, 0);
    chk(rx_status == 16'h0, "R1 status", rx_status, 0);
    chk(buf_we == 1'b0 && mem_we == 1'b0, "R1 writes", {buf_we, mem_we}, 0);
    for (int s = 0; s < 9; s++) begin
      int p;
      case (s % 3)
        0: p = 0;
        1: p = s + 2;
        default: p = 1 + s / 2;
      endcase
      run_pkt(16'(s * 16'h3A5 + 16'h0100), s, p, 32'h0000_1000 + 32'(s * 32'h100));
    end
    run_pkt(16'h0000, 2, 4, 32'h8000_0002);
    run_pkt(16'hFFFF, 5, 7, 32'h0000_0000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule